// File: doc/BRIEF.md
# Double-Buffered Serial Byte Data Register

This block sits between a CPU and a serial bit engine of a byte-oriented link controller. The CPU sees one byte-wide data location. Writing it queues a byte for transmission, and reading it returns the byte most recently received. Each direction has two stages: a holding (shadow) stage that faces the CPU and a shift stage that faces the line. The line side moves one bit per strobe from the bit engine, most-significant bit first by default.

On the transmit side, the empty flag `tdre` rises as soon as the first bit of the byte in the shift stage has been sent. This gives the CPU almost a whole byte time to supply the next byte. If the shift stage finishes a byte and no byte is waiting, the block treats this as a deliberate abort. It raises a sticky underrun flag, sends one filler bit so the frame stops off a byte boundary, and then goes idle. It starts nothing new until the CPU clears the flag.

On the receive side, each completed byte is copied into the holding stage and raises `rdrf`. The CPU clears `rdrf` with a read followed by a clear strobe. A byte that is still unread when the next byte completes is overwritten, and `ovrn` is set.

Top module: `serbyte_dreg`

## Requirements
- R1: A CPU write (`cpu_wr`) supplies the byte to transmit, and `cpu_rdata` always presents the most recently completed received byte. The data registers are not initialised by reset.
- R2: After reset `tdre`=1, `rdrf`=0, `urun`=0, `ovrn`=0 and `tx_active`=0.
- R3: A write is accepted only while `tdre`=1, and `tdre` reads 0 from the next cycle. A write made while `tdre`=0 is ignored, and the queued byte is sent unchanged.
- R4: When the transmitter is idle, `urun`=0 and a byte is queued, `tx_active` rises one cycle after the write. `tx_bit` shows the current bit (bit 7 first with defaults), and each `tx_strobe` advances one bit.
- R5: `tdre` rises on the clock edge of the `tx_strobe` that sends the first bit of the byte in the shift stage.
- R6: On the strobe that sends the last bit of a byte, a queued byte moves into the shift stage with no gap. `tx_bit` then shows its first bit.
- R7: If no byte is queued when the last bit is sent, `urun` becomes 1. `tx_active` stays 1 for one more bit period while `tx_bit` shows the filler value 1, and `tx_active` falls on the next `tx_strobe`.
- R8: While `urun`=1, no transmission starts even if a byte is queued. A `urun_clr` pulse clears `urun`, and the queued byte then starts one cycle later with its value intact.
- R9: Every 8 `rx_strobe` pulses assemble a byte from `rx_bit`, first bit to bit 7. On the last strobe the byte is copied to `cpu_rdata` and `rdrf` is set.
- R10: `rdrf` is cleared only by an `rdrf_clr` pulse that follows a `cpu_rd` made while `rdrf`=1. An `rdrf_clr` without a prior read is ignored.
- R11: A byte that completes while `rdrf`=1 overwrites `cpu_rdata` and sets `ovrn`. The read-and-clear sequence clears `ovrn` together with `rdrf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe for the data location |
| cpu_wdata | input | W | Byte to queue for transmission |
| cpu_rd | input | 1 | Read strobe, arms the receive-flag clear |
| cpu_rdata | output | W | Last received byte |
| rdrf_clr | input | 1 | Receive-full clear strobe |
| urun_clr | input | 1 | Underrun flag clear strobe |
| tdre | output | 1 | Transmit holding stage empty |
| rdrf | output | 1 | Receive holding stage full |
| urun | output | 1 | Transmit underrun (abort) flag |
| ovrn | output | 1 | Receive overwrite flag |
| tx_strobe | input | 1 | Transmit bit strobe from the bit engine |
| tx_bit | output | 1 | Current transmit bit |
| tx_active | output | 1 | Transmitter is sending |
| rx_strobe | input | 1 | Receive bit strobe from the bit engine |
| rx_bit | input | 1 | Received bit |

## Verification
Transmission is tried with a back-to-back frame of six bytes: all-ones, all-zeros, alternating and edge-bit patterns. This shows that the bit order is right, that byte chaining leaves no gap, and that the frame ends in a filler-bit abort. A single byte queued while the abort flag is set shows that the flag blocks the start and that the byte survives until the flag is cleared. On reception, the same byte table is received and cleared in the correct order. Two bytes arriving without a clear separate the overwrite path from the normal path, and a clear strobe with no prior read shows that the read is required.

// File: rtl/serbyte_pkg.sv
package serbyte_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_SHIFT = 2'd1,
      TXS_ABORT = 2'd2
   } tx_state_e;

endpackage

// File: rtl/serbyte_tx.sv
module serbyte_tx
   import serbyte_pkg::*;
#(
   parameter int   W         = 8,
   parameter bit   MSB_FIRST = 1'b1,
   parameter logic FILL_BIT  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpu_wr,
   input  logic [W-1:0] cpu_wdata,
   input  logic         urun_clr,
   input  logic         tx_strobe,
   output logic         tx_bit,
   output logic         tx_active,
   output logic         tdre,
   output logic         urun
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   tx_state_e     state_q;
   logic [W-1:0]  hold_q, shf_q, shf_nxt;
   logic          held_q, tdre_q, urun_q;
   logic [CW-1:0] idx_q;
   logic          wr_ok, idle_load, last_bit, chain, shf_load, shf_adv, out_bit;

   generate
      if (W < 2) begin : g_bad_width
         $error("serbyte_tx: W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign out_bit = shf_q[W-1];
         assign shf_nxt = {shf_q[W-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit = shf_q[0];
         assign shf_nxt = {1'b0, shf_q[W-1:1]};
      end
   endgenerate

   assign wr_ok     = cpu_wr && tdre_q;
   assign idle_load = (state_q == TXS_IDLE) && held_q && !urun_q;
   assign last_bit  = (state_q == TXS_SHIFT) && tx_strobe && (idx_q == LAST_IDX);
   assign chain     = last_bit && held_q;
   assign shf_load  = idle_load || chain;
   assign shf_adv   = (state_q == TXS_SHIFT) && tx_strobe && !chain;

   // data path: contents undefined after reset
   always_ff @(posedge clk) begin
      if (wr_ok) hold_q <= cpu_wdata;
      if (shf_load)     shf_q <= hold_q;
      else if (shf_adv) shf_q <= shf_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         held_q  <= 1'b0;
         tdre_q  <= 1'b1;
         urun_q  <= 1'b0;
         idx_q   <= '0;
      end else begin
         if (wr_ok) begin
            held_q <= 1'b1;
            tdre_q <= 1'b0;
         end
         if (urun_clr) urun_q <= 1'b0;
         unique case (state_q)
            TXS_IDLE: begin
               if (idle_load) begin
                  held_q  <= 1'b0;
                  idx_q   <= '0;
                  state_q <= TXS_SHIFT;
               end
            end
            TXS_SHIFT: begin
               if (tx_strobe) begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == '0) tdre_q <= 1'b1;
                  if (last_bit) begin
                     if (held_q) begin
                        held_q <= 1'b0;
                        idx_q  <= '0;
                     end else begin
                        urun_q  <= 1'b1;
                        state_q <= TXS_ABORT;
                     end
                  end
               end
            end
            TXS_ABORT: begin
               if (tx_strobe) state_q <= TXS_IDLE;
            end
            default: state_q <= TXS_IDLE;
         endcase
      end
   end

   assign tx_active = (state_q != TXS_IDLE);
   assign tx_bit    = (state_q == TXS_SHIFT) ? out_bit :
                      (state_q == TXS_ABORT) ? FILL_BIT : 1'b0;
   assign tdre      = tdre_q;
   assign urun      = urun_q;

   AST_WR_CLEARS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && tdre) |=> !tdre); // R3
   AST_TDRE_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == TXS_SHIFT) && tx_strobe && (idx_q == '0)) |=> tdre); // R5
   AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && !held_q) |=> (urun && tx_active)); // R7
   AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == TXS_ABORT) && tx_strobe) |=> !tx_active); // R7
   AST_NO_START_IN_URUN: assert property (@(posedge clk) disable iff (!rst_n)
      (urun && !tx_active) |=> !tx_active); // R8

endmodule

// File: rtl/serbyte_rx.sv
module serbyte_rx #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_strobe,
   input  logic         rx_bit,
   input  logic         cpu_rd,
   input  logic         rdrf_clr,
   output logic [W-1:0] cpu_rdata,
   output logic         rdrf,
   output logic         ovrn
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   logic [W-2:0]  part_q;
   logic [W-1:0]  asm_nxt, byte_q;
   logic [CW-1:0] cnt_q;
   logic          rdrf_q, ovrn_q, armed_q, done;

   generate
      if (W < 2) begin : g_bad_width
         $error("serbyte_rx: W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign asm_nxt = {part_q, rx_bit};
         always_ff @(posedge clk) if (rx_strobe) part_q <= asm_nxt[W-2:0];
      end else begin : g_lsb
         assign asm_nxt = {rx_bit, part_q};
         always_ff @(posedge clk) if (rx_strobe) part_q <= asm_nxt[W-1:1];
      end
   endgenerate

   assign done = rx_strobe && (cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (done) byte_q <= asm_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rdrf_q  <= 1'b0;
         ovrn_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (rx_strobe) cnt_q <= done ? '0 : cnt_q + 1'b1;
         if (cpu_rd && rdrf_q) armed_q <= 1'b1;
         if (rdrf_clr && armed_q) begin
            rdrf_q  <= 1'b0;
            ovrn_q  <= 1'b0;
            armed_q <= 1'b0;
         end
         if (done) begin
            rdrf_q  <= 1'b1;
            armed_q <= 1'b0;
            if (rdrf_q) ovrn_q <= 1'b1;
         end
      end
   end

   assign cpu_rdata = byte_q;
   assign rdrf      = rdrf_q;
   assign ovrn      = ovrn_q;

   AST_RDRF_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rdrf); // R9
   AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrf && !armed_q && !cpu_rd) |=> rdrf); // R10
   AST_OVRN_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdrf) |=> ovrn); // R11

endmodule

// File: rtl/serbyte_dreg.sv
module serbyte_dreg #(
   parameter int   W         = 8,
   parameter bit   MSB_FIRST = 1'b1,
   parameter logic FILL_BIT  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpu_wr,
   input  logic [W-1:0] cpu_wdata,
   input  logic         cpu_rd,
   output logic [W-1:0] cpu_rdata,
   input  logic         rdrf_clr,
   input  logic         urun_clr,
   output logic         tdre,
   output logic         rdrf,
   output logic         urun,
   output logic         ovrn,
   input  logic         tx_strobe,
   output logic         tx_bit,
   output logic         tx_active,
   input  logic         rx_strobe,
   input  logic         rx_bit
);

   serbyte_tx #(.W(W), .MSB_FIRST(MSB_FIRST), .FILL_BIT(FILL_BIT)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .urun_clr  (urun_clr),
      .tx_strobe (tx_strobe),
      .tx_bit    (tx_bit),
      .tx_active (tx_active),
      .tdre      (tdre),
      .urun      (urun)
   );

   serbyte_rx #(.W(W), .MSB_FIRST(MSB_FIRST)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_strobe (rx_strobe),
      .rx_bit    (rx_bit),
      .cpu_rd    (cpu_rd),
      .rdrf_clr  (rdrf_clr),
      .cpu_rdata (cpu_rdata),
      .rdrf      (rdrf),
      .ovrn      (ovrn)
   );

endmodule

// File: tb/serbyte_dreg_bench.sv
module serbyte_dreg_bench;

   localparam int NV = 6;
   localparam logic [7:0] VEC [NV] = '{8'hA5, 8'hFF, 8'h00, 8'h81, 8'h3C, 8'h5E};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0, rdrf_clr = 1'b0, urun_clr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       tdre, rdrf, urun, ovrn, tx_bit, tx_active;
   logic       tx_strobe = 1'b0, rx_strobe = 1'b0, rx_bit = 1'b0;
   int         checks = 0, errors = 0, cycles = 0;

   always #10 clk = ~clk;

   serbyte_dreg u_serbyte_dreg (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rdrf_clr(rdrf_clr),
      .urun_clr(urun_clr), .tdre(tdre), .rdrf(rdrf), .urun(urun), .ovrn(ovrn),
      .tx_strobe(tx_strobe), .tx_bit(tx_bit), .tx_active(tx_active),
      .rx_strobe(rx_strobe), .rx_bit(rx_bit)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b);
      cpu_wr = 1'b1; cpu_wdata = b; step(); cpu_wr = 1'b0;
   endtask

   task automatic txs();
      tx_strobe = 1'b1; step(); tx_strobe = 1'b0;
   endtask

   task automatic rxs(input logic b);
      rx_strobe = 1'b1; rx_bit = b; step(); rx_strobe = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] b);
      for (int k = 7; k >= 0; k--) rxs(b[k]);
   endtask

   task automatic read_clear();
      cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
      rdrf_clr = 1'b1; step(); rdrf_clr = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      step(); step(); step();
      rst_n = 1'b1;
      step();
      chk("R2 tdre", tdre, 1);
      chk("R2 rdrf", rdrf, 0);
      chk("R2 urun", urun, 0);
      chk("R2 ovrn", ovrn, 0);
      chk("R2 tx_active", tx_active, 0);

      // back-to-back frame walked from the vector table
      wr(VEC[0]);
      chk("R3 tdre low after write", tdre, 0);
      wr(8'h77); // ignored: tdre is 0
      chk("R4 tx_active after start", tx_active, 1);
      for (int i = 0; i < NV; i++) begin
         for (int k = 0; k < 8; k++) begin
            chk(i == 0 ? "R1 R3 R4 tx bit" : "R6 chained tx bit", tx_bit, VEC[i][7-k]);
            txs();
            if (k == 0) begin
               chk("R5 tdre after first bit", tdre, 1);
               if (i < NV - 1) wr(VEC[i+1]);
            end
         end
      end
      chk("R7 urun set", urun, 1);
      chk("R7 still active", tx_active, 1);
      chk("R7 filler bit", tx_bit, 1);
      txs();
      chk("R7 stops after filler", tx_active, 0);

      // queued byte blocked by underrun
      wr(8'hC3);
      step(); step(); step();
      chk("R8 blocked while urun", tx_active, 0);
      urun_clr = 1'b1; step(); urun_clr = 1'b0;
      chk("R8 urun cleared", urun, 0);
      step();
      chk("R8 starts after clear", tx_active, 1);
      for (int k = 0; k < 8; k++) begin
         chk("R8 byte intact", tx_bit, 8'hC3 >> (7 - k) & 1);
         txs();
      end
      txs();
      chk("R7 idle again", tx_active, 0);
      urun_clr = 1'b1; step(); urun_clr = 1'b0;

      // receive walked from the vector table
      for (int i = 0; i < NV; i++) begin
         rx_byte(VEC[i]);
         chk("R9 rdrf set", rdrf, 1);
         chk("R1 R9 rdata", cpu_rdata, VEC[i]);
         if (i == 0) begin
            rdrf_clr = 1'b1; step(); rdrf_clr = 1'b0;
            chk("R10 clear without read ignored", rdrf, 1);
         end
         read_clear();
         chk("R10 rdrf cleared", rdrf, 0);
         chk("R11 no overwrite", ovrn, 0);
      end

      // overwrite of an unread byte
      rx_byte(8'h12);
      rx_byte(8'h34);
      chk("R11 ovrn set", ovrn, 1);
      chk("R11 overwritten data", cpu_rdata, 8'h34);
      read_clear();
      chk("R11 ovrn cleared", ovrn, 0);
      chk("R11 rdrf cleared", rdrf, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule